// File: doc/BRIEF.md
# Command/Response Transfer Engine

This block carries a command into a device and a response back out through one byte-wide data port. A host feeds command bytes one at a time into a local command buffer. The engine reads the big-endian length field in bytes 2..5 of the command and uses it to decide when the command is complete. It then hands the command to an execution backend through a start/done handshake. After that it returns the backend's response one byte per read.

A status word tells the host what to do next. It combines the engine's flags with a burst count. While a response is waiting, the burst count is the number of response bytes left. At all other times it is the free space in the command buffer. The engine serves one locality. The host bus decoding, arbitration between localities and the backend itself sit outside it.

Top module: `xfer_engine`

## Requirements
- R1: After reset the engine is idle. The status word reads flags 0 with burst count CMD_DEPTH, and a data-port read returns 0x000000FF.
- R2: A command-ready request (status write bit 6) in idle moves the engine to ready, sets status bit 6 and pulses cmd_ready_evt_o. A second such request in ready changes no status bit and pulses no event.
- R3: The first data byte written in ready moves the engine to reception with status flags 0x88 (valid bit 7, expect bit 3). Each stored byte lowers the free-space burst count by one.
- R4: Once more than 5 bytes are stored, the 32-bit big-endian length in bytes 2..5 is compared with the byte count. Flags stay 0x88 while the length is larger and become 0x80 when the count reaches it. Later data bytes are dropped.
- R5: A data write while the command buffer already holds CMD_DEPTH bytes stores nothing and clears expect, leaving flags 0x80.
- R6: A go request (status write bit 5) starts execution only in reception with expect clear. start_o then pulses with cmd_len_o equal to the stored byte count. Go has no effect in any other case.
- R7: When done_i arrives during execution, the engine enters completion with flags 0x90 (valid, data-available bit 4). Both offsets reset, and data_avail_evt_o and sts_valid_evt_o pulse.
- R8: In completion, data-port reads return the response bytes in order. After the byte at the response length (bytes 2..5 of the response, big-endian), flags drop to 0x80 and sts_valid_evt_o pulses. Data reads in every other case return 0x000000FF.
- R9: The burst count (status bits 23:8) is the remaining response bytes while data-available is set. Otherwise it is CMD_DEPTH minus the stored byte count, capped at 255 for a 1-byte access.
- R10: A response-retry request (status write bit 1) in completion rewinds the read offset to 0 and restores flags 0x90.
- R11: A command-ready request in completion clears both offsets and returns to ready with flags 0x40. It pulses cmd_ready_evt_o if bit 6 was clear.
- R12: A command-ready request in reception aborts at once: the engine goes to ready with flags 0x40 and the event. In execution it pulses cancel_o, and the later done_i leads to ready with flags 0x40 and the event instead of completion.
- R13: Status writes are masked to bits 6, 5 and 1 and act only when exactly one of them is set. Data writes in idle, execution and completion are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 1 | Register access strobe, one cycle per access |
| wr_i | input | 1 | Access is a write |
| sel_fifo_i | input | 1 | 1 selects the data port, 0 the status word |
| byte_acc_i | input | 1 | Access is 1 byte wide (caps the burst count) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 32 | Read data for the selected register |
| start_o | output | 1 | Pulse: command ready for execution |
| cancel_o | output | 1 | Pulse: abort of the running command requested |
| cmd_len_o | output | CW | Stored command byte count |
| cmd_raddr_i | input | CW | Backend read address into the command buffer |
| cmd_rdata_o | output | 8 | Command byte at cmd_raddr_i |
| rsp_we_i | input | 1 | Backend response byte write |
| rsp_waddr_i | input | RW | Response byte address |
| rsp_wdata_i | input | 8 | Response byte |
| done_i | input | 1 | Backend finished (or cancelled) the command |
| cmd_ready_evt_o | output | 1 | Pulse: command-ready event |
| data_avail_evt_o | output | 1 | Pulse: response available event |
| sts_valid_evt_o | output | 1 | Pulse: status-valid event |

## Verification
On every cycle, the assertions check that data-available appears only in completion and expect only in reception. They also check that a start pulse coincides with execution and a clear expect flag, that a data-port read outside completion yields 0xFF, and that a 1-byte status read never shows a burst count above 255. They check that the write offset stays within the buffer and that done_i during execution always leaves execution. The directed scenarios are needed for the things a single-cycle property cannot see. These are the byte-exact response ordering, the length-driven end of reception, buffer-full handling, retry rewinding, and the two abort paths that end in ready rather than completion.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READY = 3'd1,
    ST_RECV  = 3'd2,
    ST_EXEC  = 3'd3,
    ST_DONE  = 3'd4
  } xfer_state_e;

  localparam int unsigned STS_VALID = 7;
  localparam int unsigned STS_CRDY  = 6;
  localparam int unsigned STS_GO    = 5;
  localparam int unsigned STS_DAV   = 4;
  localparam int unsigned STS_EXP   = 3;
  localparam int unsigned STS_RETRY = 1;
  localparam int unsigned HDR_BYTES = 6;   // length field ends at byte 5
endpackage

// File: rtl/xfer_cmd_buf.sv
module xfer_cmd_buf #(
  parameter int unsigned DEPTH = 320,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [7:0]    byte_i,
  output logic [CW-1:0] woff_o,
  output logic          full_o,
  output logic [31:0]   len_now_o,
  input  logic [CW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [CW-1:0] woff_q;
  logic [31:0]   len_q;
  logic          in_hdr;

  assign in_hdr = (woff_q >= CW'(2)) && (woff_q <= CW'(5));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      woff_q <= '0;
      len_q  <= '0;
    end else if (clr_i) begin
      woff_q <= '0;
      len_q  <= '0;
    end else if (push_i && !full_o) begin
      woff_q <= woff_q + 1'b1;
      if (in_hdr) len_q <= {len_q[23:0], byte_i};
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem_q[woff_q[AW-1:0]] <= byte_i;
  end

  // length including a byte that completes the field this cycle
  assign len_now_o = (push_i && woff_q == CW'(5)) ? {len_q[23:0], byte_i} : len_q;
  assign woff_o    = woff_q;
  assign full_o    = (32'(woff_q) >= DEPTH);
  assign rd_data_o = (32'(rd_addr_i) < DEPTH) ? mem_q[rd_addr_i[AW-1:0]] : 8'hFF;
endmodule

// File: rtl/xfer_rsp_buf.sv
module xfer_rsp_buf #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned OW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic          clr_i,
  input  logic          pop_i,
  output logic [OW-1:0] roff_o,
  output logic [OW-1:0] len_o,
  output logic [7:0]    byte_o,
  output logic          last_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [OW-1:0] roff_q;
  logic [31:0]   len_raw_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_raw_q <= '0;
    end else if (we_i && waddr_i >= AW'(2) && waddr_i <= AW'(5)) begin
      len_raw_q[8*(5 - int'(waddr_i)) +: 8] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     roff_q <= '0;
    else if (clr_i)  roff_q <= '0;
    else if (pop_i)  roff_q <= roff_q + 1'b1;
  end

  assign len_o  = (len_raw_q > DEPTH) ? OW'(DEPTH) : OW'(len_raw_q);
  assign byte_o = (32'(roff_q) < DEPTH) ? mem_q[roff_q[AW-1:0]] : 8'hFF;
  assign last_o = ({1'b0, roff_q} + 1'b1) >= {1'b0, len_o};
  assign roff_o = roff_q;
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
  import xfer_pkg::*;
#(
  parameter int unsigned CMD_DEPTH = 320,
  parameter int unsigned RSP_DEPTH = 64,
  localparam int unsigned CW = $clog2(CMD_DEPTH + 1),
  localparam int unsigned RW = $clog2(RSP_DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic          wr_i,
  input  logic          sel_fifo_i,
  input  logic          byte_acc_i,
  input  logic [7:0]    wdata_i,
  output logic [31:0]   rdata_o,
  output logic          start_o,
  output logic          cancel_o,
  output logic [CW-1:0] cmd_len_o,
  input  logic [CW-1:0] cmd_raddr_i,
  output logic [7:0]    cmd_rdata_o,
  input  logic          rsp_we_i,
  input  logic [RW-1:0] rsp_waddr_i,
  input  logic [7:0]    rsp_wdata_i,
  input  logic          done_i,
  output logic          cmd_ready_evt_o,
  output logic          data_avail_evt_o,
  output logic          sts_valid_evt_o
);
  localparam int unsigned OW = $clog2(RSP_DEPTH + 1);

  xfer_state_e st_q, st_n;
  logic valid_q, crdy_q, dav_q, exp_q, abort_q;
  logic valid_n, crdy_n, dav_n, exp_n, abort_n;
  logic start_n, cancel_n, ev_cr_n, ev_da_n, ev_sv_n;
  logic cmd_clr, rsp_clr, push, pop;

  logic [CW-1:0] woff;
  logic [CW:0]   wcnt;
  logic          cmd_full;
  logic [31:0]   len_now;
  logic [OW-1:0] roff, rsp_len;
  logic [7:0]    rsp_byte;
  logic          rsp_last;

  logic wr_sts, wr_fifo, rd_fifo, one_cmd, do_crdy, do_go, do_retry;
  logic [15:0] burst, burst_raw;
  logic [7:0]  sts_byte;

  xfer_cmd_buf #(.DEPTH(CMD_DEPTH)) u_cmd (
    .clk_i, .rst_ni, .clr_i(cmd_clr), .push_i(push), .byte_i(wdata_i),
    .woff_o(woff), .full_o(cmd_full), .len_now_o(len_now),
    .rd_addr_i(cmd_raddr_i), .rd_data_o(cmd_rdata_o)
  );

  xfer_rsp_buf #(.DEPTH(RSP_DEPTH)) u_rsp (
    .clk_i, .rst_ni, .we_i(rsp_we_i), .waddr_i(rsp_waddr_i), .wdata_i(rsp_wdata_i),
    .clr_i(rsp_clr), .pop_i(pop), .roff_o(roff), .len_o(rsp_len),
    .byte_o(rsp_byte), .last_o(rsp_last)
  );

  assign wr_sts   = acc_i & wr_i & ~sel_fifo_i;
  assign wr_fifo  = acc_i & wr_i & sel_fifo_i;
  assign rd_fifo  = acc_i & ~wr_i & sel_fifo_i;
  assign one_cmd  = $onehot({wdata_i[STS_CRDY], wdata_i[STS_GO], wdata_i[STS_RETRY]});
  assign do_crdy  = wr_sts & one_cmd & wdata_i[STS_CRDY];
  assign do_go    = wr_sts & one_cmd & wdata_i[STS_GO];
  assign do_retry = wr_sts & one_cmd & wdata_i[STS_RETRY];
  assign wcnt     = {1'b0, woff} + 1'b1;

  always_comb begin
    st_n = st_q;
    {valid_n, crdy_n, dav_n, exp_n} = {valid_q, crdy_q, dav_q, exp_q};
    abort_n = abort_q;
    {cmd_clr, rsp_clr, push, pop} = '0;
    {start_n, cancel_n, ev_cr_n, ev_da_n, ev_sv_n} = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (do_crdy) begin
          st_n = ST_READY; crdy_n = 1'b1; ev_cr_n = 1'b1;
        end
      end
      ST_READY, ST_RECV: begin
        if (do_crdy) begin
          cmd_clr = 1'b1; rsp_clr = 1'b1;
          if (st_q == ST_RECV) begin   // immediate abort, nothing running
            st_n = ST_READY;
            {valid_n, crdy_n, dav_n, exp_n} = 4'b0100;
            ev_cr_n = 1'b1;
          end
        end else if (do_go) begin
          if (st_q == ST_RECV && !exp_q) begin
            st_n = ST_EXEC; start_n = 1'b1;
          end
        end else if (wr_fifo) begin
          if (st_q == ST_READY) begin
            st_n = ST_RECV; crdy_n = 1'b0; valid_n = 1'b1;
          end
          if (st_q == ST_READY || exp_q) begin
            if (cmd_full) exp_n = 1'b0;
            else begin
              push  = 1'b1;
              exp_n = (32'(wcnt) >= HDR_BYTES) ? (len_now > 32'(wcnt)) : 1'b1;
            end
          end
        end
      end
      ST_EXEC: begin
        if (done_i) begin
          cmd_clr = 1'b1; rsp_clr = 1'b1; abort_n = 1'b0;
          if (abort_q || do_crdy) begin
            st_n = ST_READY;
            {valid_n, crdy_n, dav_n, exp_n} = 4'b0100;
            ev_cr_n = 1'b1;
          end else begin
            st_n = ST_DONE;
            {valid_n, crdy_n, dav_n, exp_n} = 4'b1010;
            ev_da_n = 1'b1; ev_sv_n = 1'b1;
          end
        end else if (do_crdy && !abort_q) begin
          abort_n = 1'b1; cancel_n = 1'b1;
        end
      end
      ST_DONE: begin
        if (do_crdy) begin
          cmd_clr = 1'b1; rsp_clr = 1'b1; st_n = ST_READY;
          {valid_n, crdy_n, dav_n, exp_n} = 4'b0100;
          ev_cr_n = ~crdy_q;
        end else if (do_retry) begin
          rsp_clr = 1'b1;
          {valid_n, crdy_n, dav_n, exp_n} = 4'b1010;
        end else if (rd_fifo && dav_q) begin
          pop = 1'b1;
          if (rsp_last) begin
            dav_n = 1'b0; ev_sv_n = 1'b1;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      {valid_q, crdy_q, dav_q, exp_q, abort_q} <= '0;
      {start_o, cancel_o, cmd_ready_evt_o, data_avail_evt_o, sts_valid_evt_o} <= '0;
    end else begin
      st_q <= st_n;
      {valid_q, crdy_q, dav_q, exp_q, abort_q} <= {valid_n, crdy_n, dav_n, exp_n, abort_n};
      {start_o, cancel_o, cmd_ready_evt_o, data_avail_evt_o, sts_valid_evt_o}
        <= {start_n, cancel_n, ev_cr_n, ev_da_n, ev_sv_n};
    end
  end

  assign burst_raw = dav_q ? (16'(rsp_len) - 16'(roff)) : (16'(CMD_DEPTH) - 16'(woff));
  assign burst     = (byte_acc_i && burst_raw > 16'd255) ? 16'd255 : burst_raw;
  assign sts_byte  = {valid_q, crdy_q, 1'b0, dav_q, exp_q, 3'b000};

  always_comb begin
    if (!sel_fifo_i)                 rdata_o = {burst, 8'h00} | {24'h0, sts_byte};
    else if (st_q == ST_DONE && dav_q) rdata_o = {24'h0, rsp_byte};
    else                             rdata_o = 32'h0000_00FF;
  end

  assign cmd_len_o = woff;
endmodule

// File: rtl/xfer_engine_chk.sv
module xfer_engine_chk
  import xfer_pkg::*;
#(
  parameter int unsigned CMD_DEPTH = 320,
  localparam int unsigned CW = $clog2(CMD_DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input xfer_state_e   state_i,
  input logic          exp_i,
  input logic          dav_i,
  input logic          start_i,
  input logic          done_i,
  input logic          acc_i,
  input logic          wr_i,
  input logic          sel_fifo_i,
  input logic          byte_acc_i,
  input logic [31:0]   rdata_i,
  input logic [CW-1:0] woff_i
);
  p_dav_in_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dav_i |-> state_i == ST_DONE);

  p_exp_in_recv_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_i |-> state_i == ST_RECV);

  p_start_exec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (state_i == ST_EXEC) && !exp_i);

  p_fifo_ff_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !wr_i && sel_fifo_i && state_i != ST_DONE) |-> rdata_i == 32'h0000_00FF);

  p_burst_cap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !wr_i && !sel_fifo_i && byte_acc_i) |-> rdata_i[31:16] == 16'h0);

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(woff_i) <= CMD_DEPTH);

  p_done_exits_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && state_i == ST_EXEC) |=> (state_i == ST_DONE || state_i == ST_READY));
endmodule

bind xfer_engine xfer_engine_chk #(.CMD_DEPTH(CMD_DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .state_i(st_q), .exp_i(exp_q), .dav_i(dav_q),
  .start_i(start_o), .done_i(done_i), .acc_i(acc_i), .wr_i(wr_i),
  .sel_fifo_i(sel_fifo_i), .byte_acc_i(byte_acc_i), .rdata_i(rdata_o), .woff_i(woff)
);

// File: tb/xfer_engine_tb_top.sv
`timescale 1ns/1ps
module xfer_engine_tb_top;
  localparam int unsigned CMD_DEPTH = 320;
  localparam int unsigned RSP_DEPTH = 64;
  localparam int unsigned CW = $clog2(CMD_DEPTH + 1);
  localparam int unsigned RW = $clog2(RSP_DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc = 0, wr = 0, sel_fifo = 0, byte_acc = 0;
  logic [7:0] wdata = '0;
  logic [31:0] rdata;
  logic start, cancel, done = 0, rsp_we = 0;
  logic [CW-1:0] cmd_len, cmd_raddr = '0;
  logic [7:0] cmd_rdata, rsp_wdata = '0;
  logic [RW-1:0] rsp_waddr = '0;
  logic ev_cr, ev_da, ev_sv;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  xfer_engine #(.CMD_DEPTH(CMD_DEPTH), .RSP_DEPTH(RSP_DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_i(acc), .wr_i(wr), .sel_fifo_i(sel_fifo),
    .byte_acc_i(byte_acc), .wdata_i(wdata), .rdata_o(rdata), .start_o(start),
    .cancel_o(cancel), .cmd_len_o(cmd_len), .cmd_raddr_i(cmd_raddr),
    .cmd_rdata_o(cmd_rdata), .rsp_we_i(rsp_we), .rsp_waddr_i(rsp_waddr),
    .rsp_wdata_i(rsp_wdata), .done_i(done), .cmd_ready_evt_o(ev_cr),
    .data_avail_evt_o(ev_da), .sts_valid_evt_o(ev_sv)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pkt_byte(int i, int len, logic [7:0] base);
    if (i >= 2 && i <= 5) return 8'(len >> (8 * (5 - i)));
    return base + 8'(i);
  endfunction

  function automatic logic [31:0] sts(int bc, logic [7:0] fl);
    return (32'(bc) << 8) | {24'h0, fl};
  endfunction

  task automatic wr_reg(bit fifo, logic [7:0] d);
    @(negedge clk); acc = 1; wr = 1; sel_fifo = fifo; wdata = d;
    @(negedge clk); acc = 0; wr = 0;
  endtask

  task automatic rd_reg(bit fifo, bit bacc, output logic [31:0] d);
    @(negedge clk); acc = 1; wr = 0; sel_fifo = fifo; byte_acc = bacc;
    #1 d = rdata;
    @(negedge clk); acc = 0; byte_acc = 0;
  endtask

  task automatic send_cmd(int nbytes, int len);
    for (int i = 0; i < nbytes; i++) wr_reg(1, pkt_byte(i, len, 8'h30));
  endtask

  task automatic backend_reply(int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk); rsp_we = 1; rsp_waddr = RW'(i); rsp_wdata = pkt_byte(i, len, 8'hA0);
    end
    @(negedge clk); rsp_we = 0; done = 1;
    @(negedge clk); done = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd_reg(0, 0, d); chk("R1 status", d, sts(CMD_DEPTH, 8'h00));
    rd_reg(1, 0, d); chk("R1 fifo", d, 32'hFF);
    rd_reg(0, 1, d); chk("R9 byte cap", d, sts(255, 8'h00));
  endtask

  task automatic t_idle_masks();
    logic [31:0] d;
    wr_reg(1, 8'h55);            // dropped in idle
    wr_reg(0, 8'h42);            // two command bits: ignored
    chk("R13 no event multi", 32'(ev_cr), 0);
    wr_reg(0, 8'h10);            // masked bit only
    rd_reg(0, 0, d); chk("R13 idle unchanged", d, sts(CMD_DEPTH, 8'h00));
  endtask

  task automatic t_cmd_ready();
    logic [31:0] d;
    wr_reg(0, 8'h40);
    chk("R2 event", 32'(ev_cr), 1);
    rd_reg(0, 0, d); chk("R2 ready status", d, sts(CMD_DEPTH, 8'h40));
    wr_reg(0, 8'h40);
    chk("R2 no second event", 32'(ev_cr), 0);
    rd_reg(0, 0, d); chk("R2 ready kept", d, sts(CMD_DEPTH, 8'h40));
  endtask

  task automatic t_command();
    logic [31:0] d;
    send_cmd(1, 10);
    rd_reg(0, 0, d); chk("R3 reception", d, sts(CMD_DEPTH - 1, 8'h88));
    for (int i = 1; i < 9; i++) wr_reg(1, pkt_byte(i, 10, 8'h30));
    rd_reg(0, 0, d); chk("R4 still expecting", d, sts(CMD_DEPTH - 9, 8'h88));
    wr_reg(0, 8'h20);
    chk("R6 go ignored with expect", 32'(start), 0);
    wr_reg(1, pkt_byte(9, 10, 8'h30));
    rd_reg(0, 0, d); chk("R4 complete", d, sts(CMD_DEPTH - 10, 8'h80));
    wr_reg(1, 8'hEE);
    rd_reg(0, 0, d); chk("R4 extra dropped", d, sts(CMD_DEPTH - 10, 8'h80));
    wr_reg(0, 8'h20);
    chk("R6 start", 32'(start), 1);
    chk("R6 length", 32'(cmd_len), 10);
    cmd_raddr = CW'(5); #1 chk("R4 stored length byte", 32'(cmd_rdata), 32'h0A);
    cmd_raddr = CW'(9); #1 chk("R3 stored last byte", 32'(cmd_rdata), 32'h39);
    wr_reg(1, 8'h77);
    rd_reg(0, 0, d); chk("R13 exec drops data", d, sts(CMD_DEPTH - 10, 8'h80));
  endtask

  task automatic t_response();
    logic [31:0] d;
    backend_reply(10);
    chk("R7 data event", 32'(ev_da), 1);
    chk("R7 status event", 32'(ev_sv), 1);
    rd_reg(0, 0, d); chk("R7 completion", d, sts(10, 8'h90));
    for (int i = 0; i < 4; i++) begin
      rd_reg(1, 1, d); chk("R8 byte", d, {24'h0, pkt_byte(i, 10, 8'hA0)});
    end
    rd_reg(0, 0, d); chk("R9 remaining", d, sts(6, 8'h90));
    for (int i = 4; i < 10; i++) begin
      rd_reg(1, 1, d); chk("R8 byte", d, {24'h0, pkt_byte(i, 10, 8'hA0)});
      if (i == 9) chk("R8 valid event", 32'(ev_sv), 1);
    end
    rd_reg(0, 0, d); chk("R8 drained", d, sts(CMD_DEPTH, 8'h80));
    rd_reg(1, 0, d); chk("R8 empty read", d, 32'hFF);
    wr_reg(0, 8'h02);
    rd_reg(0, 0, d); chk("R10 retry", d, sts(10, 8'h90));
    rd_reg(1, 0, d); chk("R10 first byte again", d, {24'h0, pkt_byte(0, 10, 8'hA0)});
    wr_reg(0, 8'h40);
    chk("R11 event", 32'(ev_cr), 1);
    rd_reg(0, 0, d); chk("R11 ready", d, sts(CMD_DEPTH, 8'h40));
  endtask

  task automatic t_aborts();
    logic [31:0] d;
    send_cmd(3, 10);
    rd_reg(0, 0, d); chk("R3 partial", d, sts(CMD_DEPTH - 3, 8'h88));
    wr_reg(0, 8'h40);
    chk("R12 reception abort event", 32'(ev_cr), 1);
    rd_reg(0, 0, d); chk("R12 reception abort", d, sts(CMD_DEPTH, 8'h40));
    send_cmd(6, 6);
    rd_reg(0, 0, d); chk("R4 short command", d, sts(CMD_DEPTH - 6, 8'h80));
    wr_reg(0, 8'h20);
    chk("R6 start short", 32'(start), 1);
    wr_reg(0, 8'h40);
    chk("R12 cancel", 32'(cancel), 1);
    backend_reply(8);
    chk("R12 no data event", 32'(ev_da), 0);
    chk("R12 ready event", 32'(ev_cr), 1);
    rd_reg(0, 0, d); chk("R12 exec abort", d, sts(CMD_DEPTH, 8'h40));
    rd_reg(1, 0, d); chk("R12 no response", d, 32'hFF);
  endtask

  task automatic t_full();
    logic [31:0] d;
    send_cmd(CMD_DEPTH, 32'h1000);
    rd_reg(0, 0, d); chk("R5 filled", d, sts(0, 8'h88));
    wr_reg(1, 8'h99);
    rd_reg(0, 0, d); chk("R5 overflow", d, sts(0, 8'h80));
    wr_reg(0, 8'h20);
    chk("R6 start full", 32'(start), 1);
    chk("R5 length", 32'(cmd_len), CMD_DEPTH);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_idle_masks();
    t_cmd_ready();
    t_command();
    t_response();
    t_aborts();
    t_full();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule